// File: doc/BRIEF.md
# Programmable Baud-Rate Clock Bank

This block holds a set of independent baud-rate clock sources. Each source owns one 32-bit control word, written through a single write port, that turns the source on, optionally places a fixed divide-by-16 prescaler in front of it, and sets the division ratio. The division ratio is stored as the wanted ratio minus one. Every source produces a square wave that a serial channel can sample or that can be routed off the chip.

All sources step on a shared enable that fires on every second cycle of the system clock. This enable acts as the sources' input clock. A source counts enabled steps up to its programmed terminal value and then inverts its output. The output period is therefore always twice the counted span. High time and low time are equal for any field value, so the even-ratio rule needed in the unprescaled mode is met by how the block is built.

Writing a control word restarts that source. Its counter, prescaler and output are cleared on the next input-clock step. The other sources keep running undisturbed.

Top module: `brg_bank`

## Requirements
- R1: After synchronous reset every source is disabled and every bit of `gen_out` is low.
- R2: The input clock of the sources is the system clock divided by 2. Outputs change only on every second system-clock cycle, counted from the first cycle after reset, except when a source is disabled.
- R3: While a source's enable bit (bit 31 of its control word) is 0, its output is driven low within one system-clock cycle and stays low.
- R4: With the prescaler off (bit 30 = 0) and field value F in bits 11:0, the output inverts once every F+1 input-clock steps. This gives a period of 4*(F+1) system-clock cycles with equal high and low times.
- R5: With bit 30 = 1, each count step takes 16 input-clock steps. The period is then 64*(F+1) system-clock cycles.
- R6: A field value of 0 with the prescaler off makes the output invert on every input-clock step, which is the fastest rate.
- R7: A write to a source clears its counter, its prescaler and its output on the next input-clock step. Counting then restarts from zero using the new word.
- R8: A write to one source does not change the output sequence of any other source.
- R9: Bits 29:12 of a control word are ignored.
- R10: `wr_idx` selects source 0 to NUM_GEN-1 directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for one control word |
| wr_idx | input | IDX_W | Index of the source being written |
| wr_data | input | 32 | Control word: bit 31 enable, bit 30 prescale, bits 11:0 ratio minus one |
| gen_out | output | NUM_GEN | Registered square-wave output of each source |

## Verification
The assertions assume that a source can only be enabled through a write. Because of this, its counter always starts from a reload, and a bound of counter against field holds between writes. They also assume that `wr_idx` stays below NUM_GEN, which the default power-of-two count guarantees. The stimulus enables sources only through the write port and drives inputs on the falling edge. It places writes at both phases of the half-rate enable, including a rewrite of a source in the middle of its count and back-to-back writes to one source while others run.

// File: rtl/brg_pkg.sv
package brg_pkg;
  localparam int CTRL_W  = 32;
  localparam int EN_BIT  = 31;
  localparam int PRE_BIT = 30;
endpackage

// File: rtl/brg_half_rate.sv
module brg_half_rate (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  always_ff @(posedge clk) begin
    if (rst) tick <= 1'b0;
    else     tick <= ~tick;
  end

  // R2: the step enable alternates every system-clock cycle
  p_tick_alt_r2: assert property (@(posedge clk) disable iff (rst) tick |=> !tick);
  p_tick_ret_r2: assert property (@(posedge clk) disable iff (rst) !tick |=> tick);
endmodule

// File: rtl/brg_cfg_regs.sv
module brg_cfg_regs #(
  parameter int NUM_GEN = 16,
  parameter int DIV_W   = 12,
  parameter int IDX_W   = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [IDX_W-1:0]          wr_idx,
  input  logic [brg_pkg::CTRL_W-1:0] wr_data,
  output logic [NUM_GEN-1:0]        en,
  output logic [NUM_GEN-1:0]        pre_sel,
  output logic [NUM_GEN-1:0][DIV_W-1:0] div,
  output logic [NUM_GEN-1:0]        load
);
  for (genvar g = 0; g < NUM_GEN; g++) begin : g_word
    assign load[g] = wr_en && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        en[g]      <= 1'b0;
        pre_sel[g] <= 1'b0;
        div[g]     <= '0;
      end else if (load[g]) begin
        en[g]      <= wr_data[brg_pkg::EN_BIT];
        pre_sel[g] <= wr_data[brg_pkg::PRE_BIT];
        div[g]     <= wr_data[DIV_W-1:0];
      end
    end
  end

  // R8: at most one word is written per cycle
  p_one_write_r8: assert property (@(posedge clk) disable iff (rst) $onehot0(load));
endmodule

// File: rtl/brg_channel.sv
module brg_channel #(
  parameter int DIV_W     = 12,
  parameter int PRE_RATIO = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             en,
  input  logic             pre_sel,
  input  logic [DIV_W-1:0] div,
  input  logic             load,
  output logic             out
);
  localparam int PRE_W = (PRE_RATIO > 1) ? $clog2(PRE_RATIO) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRE_RATIO - 1);

  logic [DIV_W-1:0] cnt;
  logic [PRE_W-1:0] pcnt;
  logic             pend;
  logic             step;

  assign step = !pre_sel || (pcnt == PRE_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      pcnt <= '0;
      out  <= 1'b0;
      pend <= 1'b0;
    end else begin
      if (!en) begin
        cnt  <= '0;
        pcnt <= '0;
        out  <= 1'b0;
        pend <= 1'b0;
      end else if (tick) begin
        if (pend) begin
          cnt  <= '0;
          pcnt <= '0;
          out  <= 1'b0;
          pend <= 1'b0;
        end else begin
          if (pre_sel) pcnt <= (pcnt == PRE_LAST) ? '0 : pcnt + 1'b1;
          if (step) begin
            if (cnt == div) begin
              cnt <= '0;
              out <= ~out;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
      end
      if (load) pend <= 1'b1;
    end
  end

  // R3: a disabled source drives low
  p_off_low_r3: assert property (@(posedge clk) disable iff (rst) !en |=> !out);
  // R2: no output change between steps while enabled
  p_hold_between_r2: assert property (@(posedge clk) disable iff (rst)
    (en && !tick) |=> $stable(out));
  // R4: counter never passes the terminal value between writes
  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (rst)
    (en && !pend) |-> (cnt <= div));
  // R5: prescaler idle when not selected
  p_pre_idle_r5: assert property (@(posedge clk) disable iff (rst)
    (en && !pend && !pre_sel) |-> (pcnt == '0));
  // R7: a pending reload clears everything on the step
  p_reload_r7: assert property (@(posedge clk) disable iff (rst)
    (en && tick && pend && !load) |=> (cnt == '0 && pcnt == '0 && !out));
endmodule

// File: rtl/brg_bank.sv
module brg_bank #(
  parameter int NUM_GEN   = 16,
  parameter int DIV_W     = 12,
  parameter int PRE_RATIO = 16,
  parameter int IDX_W     = $clog2(NUM_GEN)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [IDX_W-1:0]           wr_idx,
  input  logic [brg_pkg::CTRL_W-1:0] wr_data,
  output logic [NUM_GEN-1:0]         gen_out
);
  logic                          tick;
  logic [NUM_GEN-1:0]            en;
  logic [NUM_GEN-1:0]            pre_sel;
  logic [NUM_GEN-1:0][DIV_W-1:0] div;
  logic [NUM_GEN-1:0]            load;

  brg_half_rate u_half (
    .clk  (clk),
    .rst  (rst),
    .tick (tick)
  );

  brg_cfg_regs #(
    .NUM_GEN (NUM_GEN),
    .DIV_W   (DIV_W),
    .IDX_W   (IDX_W)
  ) u_cfg (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .en      (en),
    .pre_sel (pre_sel),
    .div     (div),
    .load    (load)
  );

  for (genvar g = 0; g < NUM_GEN; g++) begin : g_src
    brg_channel #(
      .DIV_W     (DIV_W),
      .PRE_RATIO (PRE_RATIO)
    ) u_ch (
      .clk     (clk),
      .rst     (rst),
      .tick    (tick),
      .en      (en[g]),
      .pre_sel (pre_sel[g]),
      .div     (div[g]),
      .load    (load[g]),
      .out     (gen_out[g])
    );
  end

  // R1: outputs low in the cycle after reset
  p_reset_low_r1: assert property (@(posedge clk) rst |=> (gen_out == '0));
endmodule

// File: tb/brg_bank_bench.sv
module brg_bank_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NG = 16;
  localparam int DW = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [3:0]    wr_idx = '0;
  logic [31:0]   wr_data = '0;
  logic [NG-1:0] gen_out;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;
  string cur_req = "R1";

  // reference state
  int m_cnt [NG];
  int m_pre [NG];
  bit m_out [NG];
  bit m_pend[NG];
  bit m_en  [NG];
  bit m_ps  [NG];
  int m_div [NG];
  bit m_tick;

  brg_bank u_brg_bank (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .gen_out (gen_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      for (int g = 0; g < NG; g++) begin
        m_cnt[g] = 0; m_pre[g] = 0; m_out[g] = 0; m_pend[g] = 0;
        m_en[g] = 0; m_ps[g] = 0; m_div[g] = 0;
      end
      m_tick = 0;
    end else begin
      for (int g = 0; g < NG; g++) begin
        if (!m_en[g]) begin
          m_cnt[g] = 0; m_pre[g] = 0; m_out[g] = 0; m_pend[g] = 0;
        end else if (m_tick) begin
          if (m_pend[g]) begin
            m_cnt[g] = 0; m_pre[g] = 0; m_out[g] = 0; m_pend[g] = 0;
          end else begin
            bit adv;
            adv = !m_ps[g] || (m_pre[g] == 15);
            if (m_ps[g]) m_pre[g] = (m_pre[g] == 15) ? 0 : m_pre[g] + 1;
            if (adv) begin
              if (m_cnt[g] == m_div[g]) begin
                m_cnt[g] = 0;
                m_out[g] = !m_out[g];
              end else begin
                m_cnt[g] = m_cnt[g] + 1;
              end
            end
          end
        end
      end
      m_tick = !m_tick;
      if (wr_en) begin
        m_en[wr_idx]   = wr_data[31];
        m_ps[wr_idx]   = wr_data[30];
        m_div[wr_idx]  = int'(wr_data[DW-1:0]);
        m_pend[wr_idx] = 1;
      end
    end
  end

  always @(negedge clk) begin
    if (cycles >= 1) begin
      for (int g = 0; g < NG; g++) begin
        n_cmp++;
        if (gen_out[g] !== m_out[g]) begin
          n_bad++;
          $display("FAIL %s: cycle %0d source %0d actual %b expected %b",
                   cur_req, cycles, g, gen_out[g], m_out[g]);
        end
      end
    end
    if (cycles > 200000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected under 200000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic wr(input int idx, input bit en, input bit ps, input int fld,
                    input logic [17:0] junk = '0);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_idx  = 4'(idx);
    wr_data = {en, ps, junk, 12'(fld)};
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    idle(4);
    rst = 1'b0;
    cur_req = "R1";
    idle(10);

    cur_req = "R2/R4/R9";
    wr(0, 1, 0, 2, 18'h3ffff);  // junk in ignored bits
    wr(1, 1, 0, 3);
    idle(1);                    // next write lands on the other phase
    wr(4, 1, 0, 7);
    idle(60);

    cur_req = "R6";
    wr(2, 1, 0, 0);
    idle(30);

    cur_req = "R5/R10";
    wr(3, 1, 1, 1);
    wr(15, 1, 1, 0);
    idle(300);

    cur_req = "R7";
    idle(3);
    wr(1, 1, 0, 5);             // rewrite mid-count
    idle(50);
    wr(3, 1, 0, 0);             // leave prescale mode
    idle(40);

    cur_req = "R8";
    for (int k = 0; k < 6; k++) wr(2, 1, 0, k);
    idle(40);

    cur_req = "R3";
    wr(0, 0, 0, 2);
    wr(15, 0, 1, 9);
    idle(30);

    cur_req = "R1";
    @(negedge clk) rst = 1'b1;
    idle(3);
    rst = 1'b0;
    idle(10);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule